// File: doc/BRIEF.md
# Level-Output Interrupt Aggregator with Mask Registers

This block merges a bank of interrupt request lines into one level-sensitive interrupt output for a processor. Each line passes through a synchroniser and an edge detector. A rising edge marks the line pending and a falling edge clears it. An enable mask gates the pending lines. The output is raised while any line is both pending and enabled.

A processor uses a small word-addressed register window with separate read and write strobes. It can read how many enabled lines are pending and which ones they are. It can set enable bits with one write and clear them with another. A flush write empties both the enable mask and the pending mask. After a flush, a line that stays high does not become pending again until it goes low and then high.

The registers are plain storage words rather than an explicit state machine. Only the read path has a two-phase behaviour: read data appears in the cycle after the read strobe and returns to zero in any cycle that follows an idle one.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the pending mask and the enable mask are zero, `irq_out` is low and `bus_rd_data` is zero.
- R2: A read at offset 0x00 returns the number of lines that are both pending and enabled, from 0 up to NUM_LINES. The value appears on `bus_rd_data` one clock after `bus_rd_en`.
- R3: A read at offset 0x04 returns the pending mask ANDed with the enable mask, with bit i standing for line i. It never returns the raw pending bits of disabled lines.
- R4: A write at offset 0x10 ORs bits 0..NUM_LINES-1 of the write data into the enable mask.
- R5: A write at offset 0x0C clears every enable bit whose write-data bit is 1 and leaves the other enable bits unchanged.
- R6: A write of any data at offset 0x08 clears both the enable mask and the pending mask.
- R7: A rising edge on a synchronised input line sets that line's pending bit, and a falling edge clears it. The effect is visible within six clocks. A line held high through a flush stays clear until it toggles.
- R8: `irq_out` is registered. One clock after the pending mask ANDed with the enable mask becomes non-zero, it is high, and one clock after that value becomes zero, it is low.
- R9: A read at any other address, including unaligned addresses and offsets 0x14 to 0x20, returns zero. A write at such an address changes neither mask.
- R10: In any clock that follows a clock with `bus_rd_en` low, `bus_rd_data` is zero.
- R11: A line's pending bit is kept while the line is disabled, and it shows up in reads and on `irq_out` once the line is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Asynchronous interrupt request lines |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | DATA_W | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | DATA_W | Registered read data |
| irq_out | output | 1 | Registered level interrupt to the processor |

## Verification
The bench uses the default parameters: NUM_LINES = 32, DATA_W = 32, ADDR_W = 8 and SYNC_STAGES = 2. With all 32 lines it can drive the status count to its maximum of 32 and exercise the top bit of each mask. The 8-bit address reaches every unimplemented word in the window, every unaligned byte address and addresses beyond the window, up to 0xFF. With two synchroniser stages, the settle time from an input change to a visible pending bit stays short enough for a long random sequence of line changes and mask writes.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Byte offsets of the register window. Software depends on these values.
    localparam logic [7:0] OFF_COUNT   = 8'h00;
    localparam logic [7:0] OFF_ACTIVE  = 8'h04;
    localparam logic [7:0] OFF_FLUSH   = 8'h08;
    localparam logic [7:0] OFF_EN_CLR  = 8'h0C;
    localparam logic [7:0] OFF_EN_SET  = 8'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_ACTIVE,
        SEL_FLUSH,
        SEL_EN_CLR,
        SEL_EN_SET
    } reg_sel_e;

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~last_q;
    assign fall = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/irq_mask_core.sv
module irq_mask_core #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] rise_vec,
    input  logic [NUM_LINES-1:0] fall_vec,
    input  logic                 flush,
    input  logic [NUM_LINES-1:0] en_set,
    input  logic [NUM_LINES-1:0] en_clr,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] en_q,
    output logic                 irq_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
            irq_q  <= 1'b0;
        end else begin
            // A flush wins over any edge seen in the same cycle.
            if (flush) begin
                pend_q <= '0;
                en_q   <= '0;
            end else begin
                pend_q <= (pend_q | rise_vec) & ~fall_vec;
                en_q   <= (en_q | en_set) & ~en_clr;
            end
            irq_q <= |(pend_q & en_q);
        end
    end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
    parameter int NUM_LINES = 32,
    parameter int DATA_W    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  irq_agg_pkg::reg_sel_e  sel,
    input  logic [NUM_LINES-1:0]   active,
    output logic [DATA_W-1:0]      rd_data
);
    import irq_agg_pkg::*;

    localparam int CNT_W = $clog2(NUM_LINES + 1);

    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        count = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            count = count + CNT_W'(active[i]);
        end
    end

    always_comb begin
        rd_next = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_COUNT:  rd_next = DATA_W'(count);
                SEL_ACTIVE: rd_next = DATA_W'(active);
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int NUM_LINES   = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr_en,
    input  logic [DATA_W-1:0]    bus_wr_data,
    input  logic                 bus_rd_en,
    output logic [DATA_W-1:0]    bus_rd_data,
    output logic                 irq_out
);
    import irq_agg_pkg::*;

    reg_sel_e             sel;
    logic [NUM_LINES-1:0] rise_vec, fall_vec;
    logic [NUM_LINES-1:0] pend_vec, en_vec;
    logic [NUM_LINES-1:0] set_mask, clr_mask;
    logic                 flush;

    always_comb begin
        if      (bus_addr == ADDR_W'(OFF_COUNT))  sel = SEL_COUNT;
        else if (bus_addr == ADDR_W'(OFF_ACTIVE)) sel = SEL_ACTIVE;
        else if (bus_addr == ADDR_W'(OFF_FLUSH))  sel = SEL_FLUSH;
        else if (bus_addr == ADDR_W'(OFF_EN_CLR)) sel = SEL_EN_CLR;
        else if (bus_addr == ADDR_W'(OFF_EN_SET)) sel = SEL_EN_SET;
        else                                      sel = SEL_NONE;
    end

    assign flush    = bus_wr_en && (sel == SEL_FLUSH);
    assign set_mask = (bus_wr_en && sel == SEL_EN_SET) ? bus_wr_data[NUM_LINES-1:0] : '0;
    assign clr_mask = (bus_wr_en && sel == SEL_EN_CLR) ? bus_wr_data[NUM_LINES-1:0] : '0;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irq_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (irq_in[g]),
            .rise     (rise_vec[g]),
            .fall     (fall_vec[g])
        );
    end

    irq_mask_core #(.NUM_LINES(NUM_LINES)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_vec (rise_vec),
        .fall_vec (fall_vec),
        .flush    (flush),
        .en_set   (set_mask),
        .en_clr   (clr_mask),
        .pend_q   (pend_vec),
        .en_q     (en_vec),
        .irq_q    (irq_out)
    );

    irq_read_port #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (bus_rd_en),
        .sel     (sel),
        .active  (pend_vec & en_vec),
        .rd_data (bus_rd_data)
    );
endmodule

// File: rtl/irq_aggregator_checker.sv
module irq_aggregator_checker #(
    parameter int NUM_LINES = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr_en,
    input logic [DATA_W-1:0]    bus_wr_data,
    input logic                 bus_rd_en,
    input logic [DATA_W-1:0]    bus_rd_data,
    input logic                 irq_out,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] en
);
    import irq_agg_pkg::*;

    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_out == $past(|(pend & en)));

    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(OFF_FLUSH)) |=> (pend == '0 && en == '0));

    p_en_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(OFF_EN_SET))
        |=> ((en & $past(bus_wr_data[NUM_LINES-1:0])) == $past(bus_wr_data[NUM_LINES-1:0])));

    p_en_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(OFF_EN_CLR))
        |=> ((en & $past(bus_wr_data[NUM_LINES-1:0])) == '0));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> bus_rd_data == '0);

    p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == ADDR_W'(OFF_COUNT))
        |=> bus_rd_data == DATA_W'($countones($past(pend & en))));

    p_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == ADDR_W'(OFF_ACTIVE))
        |=> bus_rd_data == DATA_W'($past(pend & en)));
endmodule

bind irq_aggregator irq_aggregator_checker #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_en   (bus_rd_en),
    .bus_rd_data (bus_rd_data),
    .irq_out     (irq_out),
    .pend        (pend_vec),
    .en          (en_vec)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
    localparam int N  = 32;
    localparam int DW = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  irq_in;
    logic [AW-1:0] bus_addr;
    logic          bus_wr_en;
    logic [DW-1:0] bus_wr_data;
    logic          bus_rd_en;
    logic [DW-1:0] bus_rd_data;
    logic          irq_out;

    always #5 clk = ~clk;

    irq_aggregator #(.NUM_LINES(N), .DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
        .bus_rd_data(bus_rd_data), .irq_out(irq_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [N-1:0] m_pend = '0, m_en = '0, m_lines = '0;

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_count();
        return DW'($countones(m_pend & m_en));
    endfunction

    task automatic bus_wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        case (a)
            8'h08: begin m_pend = '0; m_en = '0; end
            8'h0C: m_en = m_en & ~d[N-1:0];
            8'h10: m_en = m_en | d[N-1:0];
            default: ;
        endcase
    endtask

    task automatic bus_rd(logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rd_data;
    endtask

    task automatic drive_lines(logic [N-1:0] v);
        @(negedge clk);
        m_pend = (m_pend | (v & ~m_lines)) & ~(~v & m_lines);
        m_lines = v;
        irq_in = v;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_state(string tag);
        logic [DW-1:0] d;
        repeat (2) @(negedge clk);
        chk({tag, " R8 irq_out"}, DW'(irq_out), DW'(|(m_pend & m_en)));
        bus_rd(8'h00, d);
        chk({tag, " R2 count"}, d, exp_count());
        bus_rd(8'h04, d);
        chk({tag, " R3 active"}, d, DW'(m_pend & m_en));
        @(negedge clk);
        chk({tag, " R10 idle read data"}, bus_rd_data, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        report();
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'd7321));
        rst_n = 1'b0; irq_in = '0; bus_addr = '0; bus_wr_en = 1'b0;
        bus_wr_data = '0; bus_rd_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 irq_out in reset", DW'(irq_out), '0);
        chk("R1 rd_data in reset", bus_rd_data, '0);
        rst_n = 1'b1;
        check_state("R1 after reset");

        // R11: pending while disabled, appears on enable
        drive_lines(32'h0000_00F1);
        check_state("R11 disabled");
        bus_wr(8'h10, 32'h0000_0011);
        check_state("R4 R11 enable subset");

        // R5: clear some enable bits
        bus_wr(8'h10, 32'hFFFF_FFFF);
        bus_wr(8'h0C, 32'h0000_0030);
        check_state("R5 clear bits");

        // R2 full count of 32
        drive_lines('1);
        bus_wr(8'h10, 32'hFFFF_FFFF);
        check_state("R2 full");
        bus_rd(8'h00, d);
        chk("R2 count equals 32", d, 32);

        // R9 unimplemented addresses
        bus_rd(8'h14, d); chk("R9 read 0x14", d, '0);
        bus_rd(8'h20, d); chk("R9 read 0x20", d, '0);
        bus_rd(8'h02, d); chk("R9 read unaligned", d, '0);
        bus_rd(8'hFF, d); chk("R9 read 0xFF", d, '0);
        bus_wr(8'h14, 32'hFFFF_FFFF);
        bus_wr(8'h0E, 32'hFFFF_FFFF);
        bus_wr(8'h09, 32'h0);
        check_state("R9 writes ignored");

        // R6 flush with lines held high, R7 no re-pend until toggle
        bus_wr(8'h08, 32'h0);
        check_state("R6 flush");
        bus_wr(8'h10, 32'hFFFF_FFFF);
        repeat (6) @(negedge clk);
        check_state("R7 held high no re-pend");
        drive_lines(32'hFFFF_0000);
        drive_lines(32'hFFFF_00FF);
        check_state("R7 toggle re-pends");
        drive_lines(32'h0000_00FF);
        check_state("R7 fall clears");

        // random mix
        for (int it = 0; it < 60; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op <= 3)       drive_lines(N'($urandom));
            else if (op <= 5)  bus_wr(8'h10, $urandom);
            else if (op <= 7)  bus_wr(8'h0C, $urandom);
            else if (op == 8)  bus_wr(8'h08, $urandom);
            else               bus_wr(8'h18, $urandom);
            check_state("R3 random");
        end
        report();
    end
endmodule